// File: doc/BRIEF.md
# Serial Elastic Store with In-Line Bit Verification

This block is a sixteen-location, one-bit-wide elastic buffer for a serial data stream. Each incoming bit is written at the location the write pointer names, and the write pointer then moves on by one. A separate read pointer names the location presented at the output, and it advances on each read strobe. Both pointers are four bits wide and wrap modulo sixteen. After reset the write pointer starts a fixed slip (default eight) ahead of the read pointer, and all locations hold zero. The first slip reads therefore return zeros, and the written bits follow in order.

A diagnostic path checks the storage path while traffic flows. A marker strobe that arrives with a write captures two things: the write address and the bit written there. The path then watches for the read pointer to reach that address. It samples the bit read out on that read strobe and compares it with the captured copy one cycle later. A difference sets a sticky error flag, and so does an active self-test input during the compare. Only one capture is outstanding at a time. The error flag stays set until a synchronous clear is applied.

Top module: `es_elastic_chk`

## Requirements
- R1: After synchronous active-low reset, `err_flag` and `chk_busy` are 0. Every location holds 0. The read pointer is 0 and the write pointer is SLIP (8), so the first 8 reads return 0.
- R2: On a cycle with `wr_en` high, `wr_bit` is stored at the current write address, and the write address advances by one modulo 16.
- R3: `rd_bit` always shows the location at the read address. A cycle with `rd_en` high advances the read address by one modulo 16. With balanced traffic, bits come out in write order behind the SLIP reset zeros.
- R4: A cycle with `mark`, `wr_en` and no pending capture latches the write address and the written bit, and `chk_busy` is 1 from the next cycle.
- R5: `mark` has no effect while `chk_busy` is 1, and no effect on a cycle without `wr_en`.
- R6: The compare read is the `rd_en` cycle whose read address equals the latched address. At that edge `rd_bit` is sampled. The edge after it performs the compare, sets `err_flag` if the sampled bit differs from the latched bit, and returns `chk_busy` to 0.
- R7: If `self_test` is 1 during the compare cycle, `err_flag` is set even when the bits match.
- R8: `err_flag` stays 1 until a cycle with `err_clr` high, which clears it at that edge. `err_clr` takes priority over a set on the same edge.
- R9: If the latched location is overwritten with the opposite value before the read pointer reaches it, the compare sets `err_flag`. Overwriting it with the same value does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Gated input clock enable: store `wr_bit` and advance the write pointer |
| wr_bit | input | 1 | Incoming serial data bit |
| mark | input | 1 | Marker strobe that requests a diagnostic capture of the current write |
| rd_en | input | 1 | Output clock enable: advance the read pointer |
| self_test | input | 1 | Forces the compare to report a mismatch |
| err_clr | input | 1 | Synchronous clear of the error flag |
| rd_bit | output | 1 | Bit at the current read address |
| err_flag | output | 1 | Sticky diagnostic error |
| chk_busy | output | 1 | A capture is pending or its compare is running |

## Verification
The hardest case to reach from the ports is a true storage mismatch, because a correct buffer with balanced traffic never returns a wrong bit. The stimulus therefore stalls reads after a capture and writes sixteen more bits, which wraps the write pointer onto the latched location. The rewrite uses the opposite value in one run and the same value in a control run. Reads then resume until the pointer reaches that location. Ignored markers are exposed through the timing of `chk_busy`: a marker wrongly accepted while busy would move the compare point away from the one the scoreboard predicts.

// File: rtl/es_pkg.sv
package es_pkg;

  typedef enum logic [1:0] {
    DG_IDLE  = 2'd0,
    DG_ARMED = 2'd1,
    DG_CHECK = 2'd2
  } dg_state_e;

  // Next pointer value, wrapping at the buffer depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1) % depth;
  endfunction

  // Outcome of one compare: differing bits, or a forced failure.
  function automatic logic bit_mismatch(input logic sampled, input logic latched, input logic force_fail);
    return (sampled ^ latched) | force_fail;
  endfunction

endpackage

// File: rtl/es_ptr_ctr.sv
module es_ptr_ctr
  import es_pkg::*;
#(
  parameter int unsigned    PW    = 4,
  parameter logic [PW-1:0]  START = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam int unsigned DEPTH = 1 << PW;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= START;
    else if (step) ptr <= PW'(wrap_inc(32'(ptr), DEPTH));
  end
endmodule

// File: rtl/es_store.sv
module es_store #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic          wdata,
  input  logic [PW-1:0] raddr,
  output logic          rdata
);
  localparam int unsigned DEPTH = 1 << PW;

  logic [DEPTH-1:0] wsel;
  logic [DEPTH-1:0] cell_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wsel[g] = we && (waddr == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wsel[i]) cell_q[i] <= wdata;
      end
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/es_diag.sv
module es_diag
  import es_pkg::*;
#(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mark,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_addr,
  input  logic          rd_bit,
  input  logic          self_test,
  input  logic          err_clr,
  output logic [PW-1:0] lat_addr,
  output logic          cap_fire,
  output logic          cmp_fire,
  output logic          hit,
  output logic          busy,
  output logic          err_flag
);
  dg_state_e st_q;
  logic      lat_bit_q;
  logic      samp_q;
  logic      addr_eq;

  assign addr_eq  = (st_q == DG_ARMED) && (rd_addr == lat_addr);
  assign cap_fire = (st_q == DG_IDLE) && mark && wr_en;
  assign cmp_fire = (st_q == DG_CHECK);
  assign hit      = cmp_fire && bit_mismatch(samp_q, lat_bit_q, self_test);
  assign busy     = (st_q != DG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= DG_IDLE;
      lat_addr  <= '0;
      lat_bit_q <= 1'b0;
      samp_q    <= 1'b0;
    end else begin
      case (st_q)
        DG_IDLE: begin
          if (cap_fire) begin
            lat_addr  <= wr_addr;
            lat_bit_q <= wr_bit;
            st_q      <= DG_ARMED;
          end
        end
        DG_ARMED: begin
          if (addr_eq && rd_en) begin
            samp_q <= rd_bit;
            st_q   <= DG_CHECK;
          end
        end
        DG_CHECK: st_q <= DG_IDLE;
        default:  st_q <= DG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (err_clr) err_flag <= 1'b0;
    else if (hit)     err_flag <= 1'b1;
  end
endmodule

// File: rtl/es_elastic_chk.sv
module es_elastic_chk #(
  parameter int unsigned PTR_W = 4,
  parameter int unsigned SLIP  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic mark,
  input  logic rd_en,
  input  logic self_test,
  input  logic err_clr,
  output logic rd_bit,
  output logic err_flag,
  output logic chk_busy
);
  localparam int unsigned      DEPTH    = 1 << PTR_W;
  localparam logic [PTR_W-1:0] WR_START = PTR_W'(SLIP % DEPTH);
  localparam logic [PTR_W-1:0] RD_START = '0;

  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] lat_addr;
  logic             cap_fire;
  logic             cmp_fire;
  logic             hit;

  es_ptr_ctr #(.PW(PTR_W), .START(WR_START)) u_wr_ctr (
    .clk(clk), .rst_n(rst_n), .step(wr_en), .ptr(wr_ptr)
  );

  es_ptr_ctr #(.PW(PTR_W), .START(RD_START)) u_rd_ctr (
    .clk(clk), .rst_n(rst_n), .step(rd_en), .ptr(rd_ptr)
  );

  es_store #(.PW(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_ptr), .wdata(wr_bit),
    .raddr(rd_ptr), .rdata(rd_bit)
  );

  es_diag #(.PW(PTR_W)) u_diag (
    .clk(clk), .rst_n(rst_n), .mark(mark), .wr_en(wr_en), .wr_addr(wr_ptr),
    .wr_bit(wr_bit), .rd_en(rd_en), .rd_addr(rd_ptr), .rd_bit(rd_bit),
    .self_test(self_test), .err_clr(err_clr), .lat_addr(lat_addr),
    .cap_fire(cap_fire), .cmp_fire(cmp_fire), .hit(hit), .busy(chk_busy),
    .err_flag(err_flag)
  );
endmodule

// File: rtl/es_elastic_chk_sva.sv
module es_elastic_chk_sva #(
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          mark,
  input logic          self_test,
  input logic          err_clr,
  input logic          err_flag,
  input logic          chk_busy,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] lat_addr,
  input logic          cap_fire,
  input logic          cmp_fire,
  input logic          hit
);
  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_ptr == PW'($past(wr_ptr) + 1'b1));
  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr));
  assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ptr == PW'($past(rd_ptr) + 1'b1));
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_ptr));
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (chk_busy && lat_addr == $past(wr_ptr)));
  assert_mark_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && chk_busy) |-> !cap_fire);
  assert_mark_nowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !cap_fire);
  assert_cmp_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> !chk_busy);
  assert_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(hit));
  assert_selftest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && self_test && !err_clr) |=> err_flag);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_flag);
endmodule

bind es_elastic_chk es_elastic_chk_sva #(.PW(PTR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .mark(mark),
  .self_test(self_test), .err_clr(err_clr), .err_flag(err_flag),
  .chk_busy(chk_busy), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .lat_addr(lat_addr),
  .cap_fire(cap_fire), .cmp_fire(cmp_fire), .hit(hit)
);

// File: tb/es_elastic_chk_test.sv
module es_elastic_chk_test;
  localparam int SLIP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0, mark = 1'b0, rd_en = 1'b0;
  logic self_test = 1'b0, err_clr = 1'b0;
  logic rd_bit, err_flag, chk_busy;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct packed { logic val; logic tag; } item_t;
  item_t exp_q[$];
  logic  sb_on = 1'b0;
  logic  model_busy = 1'b0;
  logic  cmp_exp_err = 1'b0;
  string cmp_req = "R6";
  int    cmp_wait = 0;
  logic [7:0] lf = 8'hA5;

  always #5 clk = ~clk;

  es_elastic_chk uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .mark(mark),
    .rd_en(rd_en), .self_test(self_test), .err_clr(err_clr),
    .rd_bit(rd_bit), .err_flag(err_flag), .chk_busy(chk_busy)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    return lf[0];
  endfunction

  // Driver: one cycle of stimulus, applied at the falling edge.
  task automatic cyc(input logic we, input logic wb, input logic mk, input logic re,
                     input logic st, input logic cl);
    logic tag;
    @(negedge clk);
    wr_en = we; wr_bit = wb; mark = mk; rd_en = re; self_test = st; err_clr = cl;
    tag = mk && we && !model_busy;
    if (tag) model_busy = 1'b1;
    if (sb_on && we) exp_q.push_back('{val: wb, tag: tag});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; mark = 0; rd_en = 0; self_test = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
    for (int i = 0; i < SLIP; i++) exp_q.push_back('{val: 1'b0, tag: 1'b0});
    model_busy = 1'b0;
    cmp_wait = 0;
  endtask

  // Monitor: pops the scoreboard on every read and tracks the compare window.
  always @(negedge clk) begin
    #2;
    if (cmp_wait == 2) begin
      check("R6", "busy in compare cycle", chk_busy, 1'b1);
      model_busy = 1'b0;
      cmp_wait = 1;
    end else if (cmp_wait == 1) begin
      check("R6", "busy after compare", chk_busy, 1'b0);
      check(cmp_req, "err after compare", err_flag, cmp_exp_err);
      cmp_wait = 0;
    end
    if (sb_on && rd_en && rst_n) begin
      item_t it;
      it = exp_q.pop_front();
      check("R3", "rd_bit order", rd_bit, it.val);
      if (it.tag) cmp_wait = 2;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    #2;
    check("R1", "err after reset", err_flag, 1'b0);
    check("R1", "busy after reset", chk_busy, 1'b0);
    check("R1", "rd_bit after reset", rd_bit, 1'b0);

    // R2/R3/R4/R5: balanced stream, one capture, a marker while busy
    sb_on = 1'b1;
    cmp_exp_err = 1'b0; cmp_req = "R6";
    for (int i = 0; i < 40; i++) begin
      cyc(1, next_bit(), (i == 5) || (i == 8), 1, 0, 0);
      if (i == 6) check("R4", "busy after capture", chk_busy, 1'b1);
    end
    cyc(0, 0, 0, 0, 0, 0);
    check("R6", "no error on clean compare", err_flag, 1'b0);

    // R5: marker without a write is ignored
    cyc(0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    check("R5", "mark without wr_en", chk_busy, 1'b0);

    // R2/R3: uneven rates, capture in the middle
    for (int i = 0; i < 60; i++) begin
      cyc((i % 3) != 0, next_bit(), i == 20, (i % 3) != 1, 0, 0);
    end
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    check("R2", "no error after uneven stream", err_flag, 1'b0);

    // R7: self-test forces the error; R8 sticky and clear
    cmp_exp_err = 1'b1; cmp_req = "R7";
    for (int i = 0; i < 24; i++) cyc(1, next_bit(), i == 2, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    check("R7", "self-test error", err_flag, 1'b1);
    repeat (4) cyc(1, next_bit(), 0, 1, 0, 0);
    check("R8", "error sticky", err_flag, 1'b1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0);
    check("R8", "error cleared", err_flag, 1'b0);

    // R8: clear wins over a forced set on the same edge
    cmp_exp_err = 1'b0; cmp_req = "R8";
    for (int i = 0; i < 24; i++) cyc(1, next_bit(), i == 2, 1, 1, 1);
    cyc(0, 0, 0, 0, 0, 0);
    check("R8", "clear has priority", err_flag, 1'b0);
    check("R6", "idle after compare", chk_busy, 1'b0);

    // R9: overwrite latched location with the opposite value
    sb_on = 1'b0;
    do_reset();
    cyc(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0, 0);
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    check("R9", "overwrite detected", err_flag, 1'b1);
    check("R9", "idle after overwrite compare", chk_busy, 1'b0);

    // R9: overwrite with the same value is not an error
    do_reset();
    cyc(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0, 0);
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    check("R9", "same-value rewrite clean", err_flag, 1'b0);
    check("R9", "idle after clean compare", chk_busy, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule